// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the unsigned product of two `WIDTH`-bit operands by adding one partial product per clock. A request is made by pulsing `start` with both operands present. The block copies the multiplicand into a holding register, clears an upper accumulator and puts the multiplier into a lower register. The upper and lower registers together act as one double-width register that shifts right.

On every working cycle, the lowest bit of the lower register decides whether the multiplicand or zero is added to the upper half. The adder result and its carry are written back shifted right by one. Product bits therefore enter the lower register from the top while spent multiplier bits drop out at the bottom. After `WIDTH` such cycles, the double-width register holds the product, and `done` is raised for one cycle.

The design has a single `WIDTH`-bit adder. It suits places where area matters more than latency, and where a fixed latency of `WIDTH` working cycles is acceptable.

Top module: `seqMul`

## Requirements
- R1: While `rstN` is low and after its release, `done` is 0 and `product` is 0 until a request is accepted.
- R2: When `done` is high, `product` equals the unsigned product of the multiplicand and the multiplier that were sampled when the request was accepted, as a `2*WIDTH`-bit value.
- R3: A request accepted at rising edge k makes `done` high in the cycle that follows edge k+`WIDTH`, for exactly one cycle.
- R4: A `start` pulse that arrives while a multiplication is in progress is ignored. The running operation keeps its operands and its `done` timing, and no extra `done` follows.
- R5: The operands are sampled only at the edge that accepts the request. Changing them later in the operation does not alter the result.
- R6: After `done`, `product` holds its value until the next accepted request.
- R7: The carry out of the adder is kept on every step, so the largest operands (all ones times all ones) give the full result without loss.
- R8: An operand of zero gives a product of zero.
- R9: 13 times 11 gives 143.
- R10: A request may be made in the same cycle that `done` is high. It is accepted at the next edge, and that operation completes with R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; accepted when no operation is running |
| multiplicand | input | WIDTH | First operand, unsigned |
| multiplier | input | WIDTH | Second operand, unsigned |
| product | output | 2*WIDTH | Double-width register contents; the result once done rises |
| done | output | 1 | One-cycle pulse marking a completed product |

## Verification
The interesting overlap is the final step's completion pulse landing in the same cycle as a new request. The bench raises `start` with fresh operands exactly while `done` is high. It then judges that the earlier product was correct at that moment, that the new request is accepted, and that the second result arrives `WIDTH` cycles later with the right value. A second overlap, `start` during a running step sequence, is provoked halfway through an operation. That case is judged by unchanged result and timing, and by the absence of a second pulse.

// File: rtl/seqMulPkg.sv
package seqMulPkg;
  // Strobes sent from the sequencer to the datapath each cycle
  typedef struct packed {
    logic load;  // capture operands, clear the accumulator
    logic step;  // one add-and-shift step
  } mulStrobes_t;
endpackage

// File: rtl/seqMulPath.sv
module seqMulPath
  import seqMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobes_t        strobes,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] mcandQ;   // held multiplicand
  logic [WIDTH-1:0] accHiQ;   // upper half of the shifting register
  logic [WIDTH-1:0] accLoQ;   // lower half: multiplier bits, then product bits
  logic [WIDTH-1:0] addend;
  logic [SUM_W-1:0] sum;

  // gate each multiplicand bit with the current low multiplier bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign addend[i] = mcandQ[i] & accLoQ[0];
  end

  assign sum = {1'b0, accHiQ} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ <= '0;
      accHiQ <= '0;
      accLoQ <= '0;
    end else if (strobes.load) begin
      mcandQ <= multiplicand;
      accHiQ <= '0;
      accLoQ <= multiplier;
    end else if (strobes.step) begin
      // carry enters at the top; the sum's low bit moves into the lower half
      accHiQ <= sum[SUM_W-1:1];
      accLoQ <= {sum[0], accLoQ[WIDTH-1:1]};
    end
  end

  assign product = {accHiQ, accLoQ};
endmodule

// File: rtl/seqMulCtrl.sv
module seqMulCtrl
  import seqMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  typedef enum logic {IDLE, RUN} mulState_t;

  mulState_t       stateQ;
  logic [CNT_W-1:0] stepCnt;
  logic            doneQ;
  logic            lastStep;

  assign strobes.load = (stateQ == IDLE) && start;
  assign strobes.step = (stateQ == RUN);
  assign lastStep     = strobes.step && (stepCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (strobes.load) begin
        stateQ  <= RUN;
        stepCnt <= '0;
      end else if (lastStep) begin
        stateQ <= IDLE;
      end else if (strobes.step) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign done = doneQ;
endmodule

// File: rtl/seqMul.sv
module seqMul
  import seqMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  mulStrobes_t strobes;

  seqMulCtrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  seqMulPath #(.WIDTH(WIDTH)) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .product     (product)
  );
endmodule

// File: rtl/seqMulChk.sv
module seqMulChk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic [2*WIDTH-1:0] product,
  input logic               done
);
  localparam int PW    = 2 * WIDTH;
  localparam int CNT_W = $clog2(WIDTH + 1);

  // independent occupancy model driven from the ports only
  logic             busyM;
  logic [CNT_W-1:0] cntM;
  logic             expDone;
  logic [PW-1:0]    expProd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyM   <= 1'b0;
      cntM    <= '0;
      expDone <= 1'b0;
      expProd <= '0;
    end else begin
      expDone <= busyM && (cntM == CNT_W'(WIDTH - 1));
      if (!busyM && start) begin
        busyM   <= 1'b1;
        cntM    <= '0;
        expProd <= PW'(multiplicand) * PW'(multiplier);
      end else if (busyM) begin
        if (cntM == CNT_W'(WIDTH - 1)) busyM <= 1'b0;
        cntM <= cntM + 1'b1;
      end
    end
  end

  // R3
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    expDone |-> done);
  // R4
  done_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> expDone);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2
  product_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == expProd));
  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyM && !start) |=> $stable(product));
endmodule

bind seqMul seqMulChk #(.WIDTH(WIDTH)) i_seqMulChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .multiplicand(multiplicand),
  .multiplier  (multiplier),
  .product     (product),
  .done        (done)
);

// File: tb/test_seqMul.sv
`timescale 1ns/1ps
module test_seqMul;
  localparam int WIDTH = 8;
  localparam int PW    = 2 * WIDTH;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] multiplicand = '0;
  logic [WIDTH-1:0] multiplier = '0;
  logic [PW-1:0]    product;
  logic             done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  seqMul #(.WIDTH(WIDTH)) i_seqMul (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue a request at a falling edge; return at the falling edge where done is high.
  task automatic runMul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input string req);
    int cycles;
    logic [PW-1:0] exp;
    exp = PW'(a) * PW'(b);
    multiplicand = a;
    multiplier = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
    check(cycles == WIDTH + 1, "R3 latency", cycles, WIDTH + 1);
    check(product == exp, req, product, exp);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1 done", done, 0);
    check(product == '0, "R1 product", product, 0);
  endtask

  task automatic testBasic();
    runMul(8'd13, 8'd11, "R9 13x11");
    @(negedge clk);
    check(done == 1'b0, "R3 single pulse", done, 0);
    runMul(8'd200, 8'd3, "R2 200x3");
    @(negedge clk);
    runMul(8'd1, 8'd255, "R2 1x255");
    @(negedge clk);
  endtask

  task automatic testMax();
    runMul(8'hFF, 8'hFF, "R7 max");
    @(negedge clk);
    runMul(8'h80, 8'hFF, "R7 carry");
    @(negedge clk);
  endtask

  task automatic testZero();
    runMul(8'd0, 8'd177, "R8 zero a");
    @(negedge clk);
    runMul(8'd93, 8'd0, "R8 zero b");
    @(negedge clk);
  endtask

  task automatic testBusyStart();
    int cycles;
    multiplicand = 8'd21;
    multiplier = 8'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // request during the run, with different operands (R4)
    multiplicand = 8'd250;
    multiplier = 8'd250;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 5;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
    check(cycles == WIDTH + 1, "R4 latency", cycles, WIDTH + 1);
    check(product == 16'd126, "R4 product", product, 126);
    repeat (WIDTH + 3) begin
      @(negedge clk);
      check(done == 1'b0, "R4 no extra done", done, 0);
    end
    check(product == 16'd126, "R4 product kept", product, 126);
  endtask

  task automatic testOperandChange();
    multiplicand = 8'd37;
    multiplier = 8'd19;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    multiplicand = 8'd255;
    multiplier = 8'd1;
    repeat (WIDTH) @(negedge clk);
    check(done == 1'b1, "R5 done", done, 1);
    check(product == 16'd703, "R5 product", product, 703);
    @(negedge clk);
  endtask

  task automatic testHold();
    runMul(8'd99, 8'd77, "R2 99x77");
    multiplicand = 8'd5;
    multiplier = 8'd5;
    repeat (6) begin
      @(negedge clk);
      check(product == 16'd7623, "R6 hold", product, 7623);
    end
  endtask

  task automatic testBackToBack();
    runMul(8'd12, 8'd12, "R10 first");
    // start raised while done is high
    runMul(8'd170, 8'd85, "R10 second");
    @(negedge clk);
    check(done == 1'b0, "R10 single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testMax();
    testZero();
    testBusyStart();
    testOperandChange();
    testHold();
    testBackToBack();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule